// File: doc/BRIEF.md
# Streaming-Capable Data Tenure Controller

This block sits on the system side of a split-transaction processor bus and runs the data half of each transaction. It takes burst requests from a queue, grants the data bus, and issues one transfer acknowledge per beat. A tenure is four beats long by default. A beat may be acknowledged only when the data source says it is ready, and the first beat of a tenure may not come earlier than a limit set by where the address-retry window falls. Each beat is reported as committed once it can no longer be revoked, or as cancelled if a retry took it back.

Two operating modes are supported. In standard mode a beat stays revocable for one cycle after its acknowledge. An address retry or a data retry in that cycle cancels the beat, and the beat is sent again. Standard mode therefore needs a closing cycle after the fourth beat. In streaming mode nothing is held for late cancellation, so each beat commits as it is acknowledged. The next request can be granted during the final beat, so tenures run back to back with no idle cycle. A retry seen while streaming is a protocol violation and raises a sticky flag.

Requests use a valid/ready handshake. `req_ready` is high whenever the bus is idle. In streaming mode it is also high during the cycle of a tenure's last acknowledge, and in no other cycle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. The requester must hold its tag, window delay and `mode_stream` stable until that cycle.

Top module: `dten_ctrl`

## Requirements
- R1: `req_ready` is high in every idle cycle and low in any cycle where a transfer is in progress, apart from the cycle named in R2. `bus_grant` is high exactly in the cycles where a request is accepted, and no acknowledge is issued in the cycle a tenure is granted from idle.
- R2: In streaming mode, during the cycle of the fourth acknowledge, `req_ready` is high and a waiting request is granted in that same cycle. If its window allows, the new tenure's beat 0 is acknowledged in the very next cycle.
- R3: In standard mode, with window delay W on `req_win` (the window opens W cycles after the grant cycle), the first acknowledge comes max(1, W-1) cycles after the grant cycle when data is ready.
- R4: In streaming mode, the first acknowledge comes max(1, W) cycles after the grant cycle when data is ready.
- R5: An acknowledge is issued only while `data_rdy` is high. Beats carry indices 0, 1, 2, 3 in order on `ack_beat`, and `ack_tag` returns the request's tag.
- R6: In standard mode, `addr_retry` or `data_retry` high in the cycle after an acknowledge raises `beat_cancel`, suppresses that beat's commit, and causes the same beat index to be acknowledged again later. No acknowledge is issued in a standard-mode cycle with a retry high. A retry that does not follow an acknowledge has no effect.
- R7: In standard mode, `beat_commit` rises one cycle after each surviving acknowledge, carrying that beat's index and tag.
- R8: In streaming mode, `beat_commit` is high in the same cycle as each acknowledge, and retries never cancel a beat.
- R9: `proto_err` rises one cycle after any retry input is high while the latched mode is streaming, and stays high until reset.
- R10: `mode_stream` is sampled only when a request is accepted from idle. A streaming re-grant keeps streaming mode whatever `mode_stream` shows.
- R11: In standard mode, `req_ready` is low in the cycle after the fourth acknowledge (the closing cycle) and high in the cycle after that.
- R12: During and right after reset, `xfer_ack`, `beat_commit`, `beat_cancel` and `proto_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_stream | input | 1 | 1 selects streaming mode, sampled at acceptance from idle |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_tag | input | TAG_W | Request identifier |
| req_win | input | WIN_W | Cycles from grant to first cycle of the address-retry window |
| data_rdy | input | 1 | Data source can supply a beat this cycle |
| addr_retry | input | 1 | Address retry |
| data_retry | input | 1 | Data retry |
| bus_grant | output | 1 | Data bus grant, high in the acceptance cycle |
| xfer_ack | output | 1 | Transfer acknowledge for one beat |
| ack_beat | output | BEAT_W | Index of the acknowledged beat |
| ack_tag | output | TAG_W | Tag of the current tenure |
| beat_commit | output | 1 | A beat has become final |
| commit_beat | output | BEAT_W | Index of the committed beat |
| commit_tag | output | TAG_W | Tag of the committed beat |
| beat_cancel | output | 1 | The previously acknowledged beat is revoked |
| proto_err | output | 1 | Sticky flag: retry seen in streaming mode |

## Verification
In standard mode, the commit of one beat falls in the same cycle as the acknowledge of the next beat. A retry in that cycle must turn the commit into a cancel and must also hold back the acknowledge. The bench provokes this by raising a data retry right after beat 0, and an address retry right after beat 3 while the tenure is closing. It then checks that `beat_cancel` rises, that no commit or acknowledge appears in that cycle, and that the same index is acknowledged again. In streaming mode, the final acknowledge and the grant of the next tenure share one cycle. The bench offers the next request in exactly that cycle, with `mode_stream` flipped, and judges the gap-free beat 0 that follows and its same-cycle commit. A scoreboard matches every commit against the tags and beat indices that the stimulus expects.

// File: rtl/dten_pkg.sv
package dten_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_CLOSE = 2'd2
  } dten_state_e;
endpackage

// File: rtl/dten_window.sv
// Counts down from the grant to the opening of the address-retry window.
module dten_window #(
  parameter int WIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIN_W-1:0] win_in,
  output logic             ok_std,
  output logic             ok_stream
);
  logic [WIN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= (win_in == '0) ? '0 : win_in - WIN_W'(1);
    else if (cnt != '0)  cnt <= cnt - WIN_W'(1);
  end

  // Standard mode may move one cycle ahead of the window; streaming may not.
  assign ok_std    = (cnt <= WIN_W'(1));
  assign ok_stream = (cnt == '0);

  AST_WIN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - WIN_W'(1))); // R3
endmodule

// File: rtl/dten_beats.sv
// Tracks how many beats of the tenure are acknowledged and not revoked.
module dten_beats #(
  parameter  int BEATS  = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int CNT_W  = $clog2(BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ack,
  input  logic              cancel,
  output logic [BEAT_W-1:0] idx,
  output logic              last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (ack && !cancel)   cnt <= cnt + CNT_W'(1);
    else if (cancel && !ack)   cnt <= cnt - CNT_W'(1);
  end

  assign idx  = cnt[BEAT_W-1:0];
  assign last = (cnt == CNT_W'(BEATS - 1));

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BEATS)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |-> (cnt != '0)); // R6
endmodule

// File: rtl/dten_ctrl.sv
module dten_ctrl #(
  parameter  int TAG_W  = 4,
  parameter  int WIN_W  = 3,
  parameter  int BEATS  = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_stream,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [WIN_W-1:0]  req_win,
  input  logic              data_rdy,
  input  logic              addr_retry,
  input  logic              data_retry,
  output logic              bus_grant,
  output logic              xfer_ack,
  output logic [BEAT_W-1:0] ack_beat,
  output logic [TAG_W-1:0]  ack_tag,
  output logic              beat_commit,
  output logic [BEAT_W-1:0] commit_beat,
  output logic [TAG_W-1:0]  commit_tag,
  output logic              beat_cancel,
  output logic              proto_err
);
  import dten_pkg::*;

  dten_state_e       st, st_nxt;
  logic              cur_stream;
  logic [TAG_W-1:0]  tag_q;
  logic              ack_q;
  logic [BEAT_W-1:0] ackb_q;
  logic              err_q;
  logic              ok_std, ok_stream, win_ok;
  logic              last;
  logic [BEAT_W-1:0] idx;
  logic              retry, accept;

  dten_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .load(accept), .win_in(req_win),
    .ok_std(ok_std), .ok_stream(ok_stream)
  );

  dten_beats #(.BEATS(BEATS)) u_beats (
    .clk(clk), .rst_n(rst_n), .clear(accept), .ack(xfer_ack),
    .cancel(beat_cancel), .idx(idx), .last(last)
  );

  assign retry  = addr_retry | data_retry;
  assign win_ok = cur_stream ? ok_stream : ok_std;

  // Standard mode holds back a beat while a retry is on the bus.
  assign xfer_ack    = (st == ST_XFER) && data_rdy && win_ok && (cur_stream || !retry);
  assign beat_cancel = !cur_stream && ack_q && retry;
  assign req_ready   = (st == ST_IDLE) ||
                       ((st == ST_XFER) && cur_stream && xfer_ack && last);
  assign accept      = req_valid && req_ready;
  assign bus_grant   = accept;

  assign ack_beat    = idx;
  assign ack_tag     = tag_q;
  assign beat_commit = cur_stream ? xfer_ack : (ack_q && !retry);
  assign commit_beat = cur_stream ? idx : ackb_q;
  assign commit_tag  = tag_q;
  assign proto_err   = err_q;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:  if (accept) st_nxt = ST_XFER;
      ST_XFER:  if (xfer_ack && last) begin
                  if (!cur_stream)  st_nxt = ST_CLOSE;
                  else if (!accept) st_nxt = ST_IDLE;
                end
      ST_CLOSE: st_nxt = beat_cancel ? ST_XFER : ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_stream <= 1'b0;
      tag_q      <= '0;
      ack_q      <= 1'b0;
      ackb_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      st     <= st_nxt;
      ack_q  <= xfer_ack && !cur_stream;
      ackb_q <= idx;
      if (accept) tag_q <= req_tag;
      if (accept && st == ST_IDLE) cur_stream <= mode_stream;
      if (cur_stream && retry) err_q <= 1'b1;
    end
  end

  AST_NO_ACK_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && st == ST_IDLE) |-> !xfer_ack); // R1
  AST_CANCEL_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cancel |-> $past(xfer_ack)); // R6
  AST_STD_COMMIT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_stream && beat_commit) |-> $past(xfer_ack)); // R7
  AST_STREAM_NEVER_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    cur_stream |-> !beat_cancel); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(cur_stream)); // R10
endmodule

// File: tb/dten_ctrl_bench.sv
module dten_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_stream = 1'b0, req_valid = 1'b0, data_rdy = 1'b0;
  logic       addr_retry = 1'b0, data_retry = 1'b0;
  logic [3:0] req_tag = '0;
  logic [2:0] req_win = '0;
  logic       req_ready, bus_grant, xfer_ack, beat_commit, beat_cancel, proto_err;
  logic [1:0] ack_beat, commit_beat;
  logic [3:0] ack_tag, commit_tag;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dten_ctrl u_dten_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_stream(mode_stream), .req_valid(req_valid),
    .req_ready(req_ready), .req_tag(req_tag), .req_win(req_win), .data_rdy(data_rdy),
    .addr_retry(addr_retry), .data_retry(data_retry), .bus_grant(bus_grant),
    .xfer_ack(xfer_ack), .ack_beat(ack_beat), .ack_tag(ack_tag),
    .beat_commit(beat_commit), .commit_beat(commit_beat), .commit_tag(commit_tag),
    .beat_cancel(beat_cancel), .proto_err(proto_err)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic push4(input int tag);
    for (int b = 0; b < 4; b++) exp_q.push_back({4'(tag), 2'b00, 2'(b)});
  endtask

  task automatic grant(input int tag, input int win, input bit strm);
    @(negedge clk);
    req_valid = 1'b1; req_tag = 4'(tag); req_win = 3'(win); mode_stream = strm;
    data_rdy = 1'b1; addr_retry = 1'b0; data_retry = 1'b0;
    #1;
    chk("R1 grant", int'(bus_grant), 1);
  endtask

  task automatic step(input bit rdy, input bit ar, input bit dr);
    @(negedge clk);
    req_valid = 1'b0; data_rdy = rdy; addr_retry = ar; data_retry = dr;
    #1;
  endtask

  // Timing run of one tenure with data always ready.
  task automatic tenure(input int tag, input int win, input bit strm, input int first, input string rq);
    int k = 0;
    grant(tag, win, strm);
    push4(tag);
    do begin step(1, 0, 0); k++; end while (!xfer_ack && k < 20);
    chk(rq, k, first);
    chk("R5 beat0", int'(ack_beat), 0);
    chk("R5 tag", int'(ack_tag), tag);
    chk(strm ? "R8 same-cycle commit" : "R7 no commit on ack", int'(beat_commit), int'(strm));
    for (int b = 1; b < 4; b++) begin
      step(1, 0, 0);
      chk("R5 ack", int'(xfer_ack), 1);
      chk("R5 beat idx", int'(ack_beat), b);
      if (b == 1) chk("R1 busy", int'(req_ready), 0);
    end
    step(1, 0, 0);
    if (!strm) begin
      chk("R7 last commit", int'(beat_commit), 1);
      chk("R7 last idx", int'(commit_beat), 3);
      chk("R11 close", int'(req_ready), 0);
      step(1, 0, 0);
      chk("R11 reopen", int'(req_ready), 1);
    end else begin
      chk("R1 idle ready", int'(req_ready), 1);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && beat_commit) begin
      if (exp_q.size() == 0) chk("R7 unexpected commit", int'({commit_tag, 2'b00, commit_beat}), 0);
      else chk("R7 commit item", int'({commit_tag, 2'b00, commit_beat}), int'(exp_q.pop_front()));
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R12 ack", int'(xfer_ack), 0);
    chk("R12 commit", int'(beat_commit), 0);
    chk("R12 cancel", int'(beat_cancel), 0);
    chk("R12 err", int'(proto_err), 0);
    chk("R12 ready", int'(req_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R12 ready after reset", int'(req_ready), 1);

    tenure(5, 3, 1'b0, 2, "R3 std W=3");
    tenure(6, 0, 1'b0, 1, "R3 std W=0");
    tenure(10, 3, 1'b1, 3, "R4 stream W=3");
    tenure(11, 1, 1'b1, 1, "R4 stream W=1");

    // Waits from the data source (standard)
    grant(3, 1, 1'b0); push4(3);
    step(0, 0, 0); chk("R5 no ack without data", int'(xfer_ack), 0);
    step(1, 0, 0); chk("R5 ack b0", int'(xfer_ack), 1);
    step(0, 0, 0); chk("R5 wait", int'(xfer_ack), 0); chk("R7 commit during wait", int'(beat_commit), 1);
    step(1, 0, 0); chk("R5 b1", int'(ack_beat), 1);
    step(1, 0, 0); step(1, 0, 0); chk("R5 b3", int'(ack_beat), 3);
    step(1, 0, 0); step(1, 0, 0);

    // Standard cancellation by data retry and by address retry in the close cycle
    grant(7, 1, 1'b0); push4(7);
    step(1, 0, 0); chk("R6 b0", int'(xfer_ack), 1);
    step(1, 0, 1);
    chk("R6 cancel", int'(beat_cancel), 1); chk("R6 no ack", int'(xfer_ack), 0);
    chk("R6 no commit", int'(beat_commit), 0);
    step(1, 0, 0); chk("R6 re-ack", int'(xfer_ack), 1); chk("R6 same idx", int'(ack_beat), 0);
    step(1, 0, 0); chk("R7 commit b0", int'(beat_commit), 1);
    step(1, 0, 0); step(1, 0, 0); chk("R6 b3", int'(ack_beat), 3);
    step(1, 1, 0); chk("R6 addr cancel", int'(beat_cancel), 1); chk("R6 no commit b3", int'(beat_commit), 0);
    step(1, 0, 0); chk("R6 re-ack b3", int'(xfer_ack), 1); chk("R6 idx3", int'(ack_beat), 3);
    step(1, 0, 0); chk("R11 close", int'(req_ready), 0);
    step(1, 0, 0);
    step(0, 1, 1); chk("R6 idle retry no cancel", int'(beat_cancel), 0);
    step(0, 0, 0); chk("R9 no err in std", int'(proto_err), 0);

    // Streaming back-to-back with mode flipped at re-grant
    grant(1, 1, 1'b1); push4(1); push4(2);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_tag = 4'd2; req_win = 3'd1; mode_stream = 1'b0; data_rdy = 1'b1;
    #1;
    chk("R2 last ack", int'(xfer_ack), 1); chk("R2 idx", int'(ack_beat), 3);
    chk("R2 ready", int'(req_ready), 1); chk("R2 grant", int'(bus_grant), 1);
    step(1, 0, 0);
    chk("R2 no gap", int'(xfer_ack), 1); chk("R2 beat0", int'(ack_beat), 0);
    chk("R2 new tag", int'(ack_tag), 2); chk("R10 still streaming", int'(beat_commit), 1);
    step(1, 0, 0);
    step(1, 0, 1); chk("R8 no cancel", int'(beat_cancel), 0); chk("R8 commit kept", int'(beat_commit), 1);
    step(1, 0, 0); chk("R9 err raised", int'(proto_err), 1);
    step(1, 0, 0); chk("R9 err sticky", int'(proto_err), 1);
    step(0, 0, 0); step(0, 0, 0);
    chk("R7 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule